// File: doc/BRIEF.md
# Serial GPIO Target Front End for an SPI Slave

This block sits between a serial GPIO initiator (the backplane controller that drives the clock, frame-load and outbound data lines) and a plain SPI slave serializer. The initiator's clock and outbound data go straight through to the SPI slave's clock and MOSI pins. The SPI slave's MISO is registered in the system clock domain and returned as the target's inbound data line. This lets a standard mode-0, LSB-first, active-high-select SPI slave take a frame of any length.

An SPI slave needs a select that frames a whole transfer, and the initiator does not supply one. The block builds it. The frame-load and clock lines each pass two synchronizing flops. A falling edge of the clock is found by comparing the synchronized clock with a copy delayed by one cycle. On each such edge the synchronized frame-load level is sampled. If it is high, the frame has started and the select goes high. An idle counter is cleared by every detected falling edge and otherwise counts system clocks. When it reaches its top value with no new edge, the clock is treated as stopped and the select drops. The vendor bits that follow the start bit on the frame-load line do not affect the select, and the block does not decode the drive status fields.

Top module: `sgpio_spi_front`

## Requirements
- R1: `spi_sck_o` is a combinational copy of `sclock_i`.
- R2: `spi_mosi_o` is a combinational copy of `sdataout_i`.
- R3: After each rising edge of `clk_i`, `sdatain_o` holds the value `spi_miso_i` had at that edge.
- R4: While `rst_ni` is low, `spi_ss_o` and `sdatain_o` are 0.
- R5: A falling transition of `sclock_i` is captured on the third rising `clk_i` edge after it first reaches the input. If `sload_i` is high at that point (sampled through the same two-flop delay), `spi_ss_o` is 1 after that third edge.
- R6: A high level on `sload_i` that does not overlap a captured falling edge of `sclock_i` does not raise `spi_ss_o`. Examples are a high level seen only around a rising edge, or while the clock is held steady.
- R7: Once raised, `spi_ss_o` stays 1 as long as successive captured falling edges are at most 256 `clk_i` cycles apart. This holds whatever `sload_i` carries on those edges (vendor bits 1 to 4, zeros after them).
- R8: If 256 `clk_i` rising edges pass after a captured falling edge with no new one captured, `spi_ss_o` becomes 0 on the 256th edge. This is the 8-bit idle counter reaching 255.
- R9: After the idle timeout, `spi_ss_o` stays 0 when the clock resumes with `sload_i` low. It rises again only on a captured falling edge with `sload_i` high.
- R10: From reset release, `spi_ss_o` stays 0 until the first captured falling edge that finds `sload_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclock_i | input | 1 | Serial clock from the initiator |
| sload_i | input | 1 | Frame-load / vendor bit line from the initiator |
| sdataout_i | input | 1 | Outbound serial data from the initiator |
| spi_miso_i | input | 1 | MISO from the SPI slave serializer |
| spi_sck_o | output | 1 | SPI slave clock (pass-through) |
| spi_mosi_o | output | 1 | SPI slave MOSI (pass-through) |
| spi_ss_o | output | 1 | Rebuilt active-high slave select |
| sdatain_o | output | 1 | Inbound serial data to the initiator (registered MISO) |

## Verification
The two pass-throughs are due in the same cycle and are checked one time unit after each input change. The returned data line is due one edge after MISO is sampled. The select reacts on the third edge after a clock fall, and times out on the 256th edge after the last captured fall. The bench keeps a four-deep history of the clock and frame-load inputs taken at each rising edge. From it, the bench works out in which edge a fall is captured and what frame-load level goes with it. It checks every output at the falling edge after each rising edge, so the comparison never races a register update. Directed idle gaps of exactly 256 and 257 cycles check the timeout boundary from both sides.

// File: rtl/sgpio_fe_pkg.sv
package sgpio_fe_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned IDLE_CNT_W  = 8;

  typedef struct packed {
    logic sclk;
    logic sload;
  } fe_ctl_t;

  localparam int unsigned FE_CTL_W = $bits(fe_ctl_t);
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fe_fall_detect.sv
module fe_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl_i;
  end

  assign fall_o = lvl_d_q & ~lvl_i;
endmodule

// File: rtl/fe_idle_timer.sv
module fe_idle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // wraps freely; only the terminal value is observed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (fall_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == CNT_MAX) & ~fall_i;

  // R7
  clr_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !expire_o);
endmodule

// File: rtl/sgpio_spi_front.sv
module sgpio_spi_front
  import sgpio_fe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclock_i,
  input  logic sload_i,
  input  logic sdataout_i,
  input  logic spi_miso_i,
  output logic spi_sck_o,
  output logic spi_mosi_o,
  output logic spi_ss_o,
  output logic sdatain_o
);
  fe_ctl_t ctl_raw, ctl_s;
  logic    sclk_fall;
  logic    idle_expire;
  logic    ss_q;
  logic    sdatain_q;

  assign spi_sck_o  = sclock_i;
  assign spi_mosi_o = sdataout_i;

  assign ctl_raw.sclk  = sclock_i;
  assign ctl_raw.sload = sload_i;

  fe_sync #(
    .WIDTH  (FE_CTL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  fe_fall_detect u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctl_s.sclk),
    .fall_o (sclk_fall)
  );

  fe_idle_timer #(
    .CNT_W (IDLE_CNT_W)
  ) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (sclk_fall),
    .expire_o (idle_expire)
  );

  // frame start sets, idle timeout clears; timer output already masks a same-cycle fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ss_q <= 1'b0;
    else if (sclk_fall && ctl_s.sload) ss_q <= 1'b1;
    else if (idle_expire)             ss_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdatain_q <= 1'b0;
    else         sdatain_q <= spi_miso_i;
  end

  assign spi_ss_o  = ss_q;
  assign sdatain_o = sdatain_q;

  // R5
  ss_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_ss_o) |-> $past(sclk_fall && ctl_s.sload));

  // R8
  ss_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_ss_o && idle_expire) |=> !spi_ss_o);

  // R9
  ss_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_ss_o) |-> $past(idle_expire));

  // R3
  miso_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sdatain_o == $past(spi_miso_i)));
endmodule

// File: tb/sgpio_spi_front_bench.sv
module sgpio_spi_front_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic sclock, sload, sdo, miso;
  logic sck, mosi, ss, sdatain;

  always #5 clk = ~clk;

  sgpio_spi_front u_sgpio_spi_front (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclock_i   (sclock),
    .sload_i    (sload),
    .sdataout_i (sdo),
    .spi_miso_i (miso),
    .spi_sck_o  (sck),
    .spi_mosi_o (mosi),
    .spi_ss_o   (ss),
    .sdatain_o  (sdatain)
  );

  int    errors = 0;
  int    checks = 0;
  int    n = 0;
  int    last_fall = -100000;
  logic [3:0] vh = '0;
  logic [3:0] lh = '0;
  logic  ss_m = 1'b0;
  logic  miso_exp;
  logic  done = 1'b0;
  logic  saw_ss = 1'b0;
  string phase = "R10";

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b cycle=%0d", req, what, act, exp, n);
    end
  endtask

  // expected select after a rising edge, from the input history
  function automatic logic next_ss(logic cur, logic fall_cap, logic ld_cap, int idle);
    if (fall_cap) return cur | ld_cap;
    if (idle == 256) return 1'b0;
    return cur;
  endfunction

  task automatic tick();
    logic fc;
    #1;
    check("R1", sck, sclock, "spi_sck_o");
    check("R2", mosi, sdo, "spi_mosi_o");
    @(posedge clk);
    n++;
    vh = {vh[2:0], sclock};
    lh = {lh[2:0], sload};
    miso_exp = miso;
    fc = vh[3] & ~vh[2];
    ss_m = next_ss(ss_m, fc, lh[2], n - last_fall);
    if (fc) last_fall = n;
    @(negedge clk);
    check(phase, ss, ss_m, "spi_ss_o");
    check("R3", sdatain, miso_exp, "sdatain_o");
    if (ss) saw_ss = 1'b1;
    miso = 1'($urandom);
  endtask

  task automatic hold(int cyc);
    for (int i = 0; i < cyc; i++) tick();
  endtask

  task automatic bit_out(logic ld, logic d, int lo, int hi);
    sclock = 1'b0; sload = ld; sdo = d;
    hold(lo);
    sclock = 1'b1;
    hold(hi);
  endtask

  task automatic frame(int nbits, int lmax);
    for (int b = 0; b < nbits; b++) begin
      logic ld;
      ld = (b == 0) ? 1'b1 : ((b <= 4) ? 1'($urandom) : 1'b0);
      bit_out(ld, 1'($urandom), 2 + int'($urandom % lmax), 2 + int'($urandom % lmax));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sclock = 1'b0; sload = 1'b0; sdo = 1'b0; miso = 1'b1;
    repeat (4) @(negedge clk);
    check("R4", ss, 1'b0, "spi_ss_o in reset");
    check("R4", sdatain, 1'b0, "sdatain_o in reset");
    rst_n = 1'b1;

    // R10: idle and clocking without a frame start
    phase = "R10";
    hold(20);
    for (int b = 0; b < 6; b++) bit_out(1'b0, 1'($urandom), 4, 4);

    // R6: load high only around a rising edge, then with the clock held
    phase = "R6";
    sclock = 1'b1; sload = 1'b1; hold(10);
    sload = 1'b0; hold(5);
    sclock = 1'b0; hold(6);
    sload = 1'b1; hold(30);
    sload = 1'b0; sclock = 1'b1; hold(6);
    check("R6", saw_ss, 1'b0, "select never raised");

    // R5/R7: random frames with vendor bits
    phase = "R5";
    frame(12, 10);
    check("R5", saw_ss, 1'b1, "select raised by frame start");
    phase = "R7";
    for (int f = 0; f < 6; f++) frame(8 + int'($urandom % 9), 12);

    // R7: fall-to-fall gap of exactly 256 cycles keeps select
    bit_out(1'b0, 1'b1, 128, 128);
    bit_out(1'b0, 1'b0, 3, 3);
    check("R7", ss, 1'b1, "select held across 256 gap");

    // R8: gap of 257 drops select just before the late fall
    phase = "R8";
    bit_out(1'b0, 1'b1, 128, 129);
    phase = "R9";
    for (int b = 0; b < 5; b++) bit_out(1'b0, 1'($urandom), 3, 3);
    check("R9", ss, 1'b0, "select low after timeout");

    // R8: full stop then R9 resume
    phase = "R5";
    frame(10, 6);
    phase = "R8";
    sclock = 1'b0; hold(300);
    check("R8", ss, 1'b0, "select low after clock stop");
    phase = "R9";
    for (int b = 0; b < 8; b++) bit_out(1'b0, 1'($urandom), 2 + int'($urandom % 5), 3);
    phase = "R5";
    frame(12, 8);
    check("R5", ss, 1'b1, "select raised after restart");
    phase = "R8";
    sclock = 1'b0; hold(270);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule